// File: doc/BRIEF.md
# Register Compare Flag Unit

This block carries out the register-to-register forms of a compare instruction. It is given a 16-bit instruction word together with a start strobe. It decodes the word and reads two operands through a combinational register-file read port, one for the destination data register and one for the source data or address register. It then subtracts the source from the destination at byte, word or long width. It does not write the result anywhere. It only produces new N, Z, V and C condition bits, and it keeps the X bit that the surrounding core presents with the start strobe.

The unit also models execution time. While it runs it holds a busy indication. When the instruction's cycle count has elapsed, it raises a one-cycle completion strobe and updates the condition-code output at the same edge. Long compares take longer than byte and word compares. The cycle count of the instruction is available on a separate output. If the instruction word is not a supported form, the unit raises an illegal-instruction strobe and leaves the condition bits alone.

Top module: `cmp_ccr_unit`

## Requirements
- R1: An instruction is legal only when all of the following hold:
  - bits 15..12 are 1011;
  - bits 8..6 are 000 (byte), 001 (word) or 010 (long);
  - bits 5..3 are 000 (data-register source) or 001 (address-register source).
  
  Bits 11..9 give the destination data register, which is driven on `dst_sel`. `src_sel` is driven as {bit 3, bits 2..0}: its bit 3 is 1 for the address-register file and 0 for the data-register file.
- R2: `cc_out` is laid out as [4]=X, [3]=N, [2]=Z, [1]=V, [0]=C, and the flags are computed from r = destination − source at the selected width:
  - N is the top bit of r;
  - Z is set when r is zero;
  - C is set when the source, read as unsigned, exceeds the destination;
  - V is set when the operands' top bits differ and r's top bit differs from the destination's top bit.
- R3: Byte and word compares use only the low 8 or 16 bits of each operand. Higher bits have no effect on any flag.
- R4: On completion, the X bit of `cc_out` takes the value `cc_x_in` had when the instruction was accepted.
- R5: `done` rises exactly 4 clock edges after the edge that accepts a byte or word compare, and exactly 6 edges after the edge that accepts a long compare. From acceptance until completion, `cycles` shows this count.
- R6: An address-register source is accepted for word and long sizes. It uses the same timing as a data-register source of the same size.
- R7: An illegal word, or a byte compare with an address-register source, produces a one-cycle `illegal` pulse one edge after acceptance. In that case `cc_out` is not changed and no `done` follows.
- R8: `cc_out` changes only in the cycle where `done` is high, and `done` lasts one cycle.
- R9: A `start` while `busy` is high is ignored. No extra completion or illegal pulse results, and the running instruction's flags are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept `opcode` when not busy |
| opcode | input | 16 | Instruction word |
| cc_x_in | input | 1 | X bit to carry through |
| dst_sel | output | 3 | Destination data-register index |
| dst_data | input | 32 | Destination register value |
| src_sel | output | 4 | Source select: bit 3 picks the address file, bits 2..0 the index |
| src_data | input | 32 | Source register value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | One-cycle unsupported-instruction strobe |
| cycles | output | 4 | Cycle count of the accepted instruction |
| cc_out | output | 5 | Condition bits {X,N,Z,V,C} |

## Verification
The hardest case to reach from the ports is a second `start` that arrives while a long compare is still counting. The running instruction must finish with its own flags, and the new request must leave no trace. The stimulus drives exactly that: two edges into a six-cycle compare, it presents a byte compare whose flags would differ. The scoreboard then requires exactly one completion with the long compare's flags. Overflow and borrow cases come from operand pairs that straddle the sign boundary at each width. Junk in the upper bits of byte operands shows that only the low lane is used.

// File: rtl/cmp_ccr_pkg.sv
// Package: shared widths, size encoding and the decoded-instruction record
// for the register compare unit. Assumes 32-bit registers.
package cmp_ccr_pkg;

    localparam int REG_W = 32;
    localparam int CYC_W = 4;

    // Operand size as carried in instruction bits 7..6 (bit 8 must be zero)
    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10
    } opsize_e;

    // Everything the datapath needs from one instruction word
    typedef struct packed {
        logic             legal;
        opsize_e          size;
        logic [2:0]       dst_idx;
        logic             src_addr;
        logic [2:0]       src_idx;
        logic [CYC_W-1:0] cyc;
    } cmp_dec_t;

endpackage

// File: rtl/cmp_decode.sv
// Module: cmp_decode
// Purely combinational decode of one compare instruction word into register
// selects, operand size, legality and execution cycle count.
// Assumes the caller samples the result only when it accepts the word.
module cmp_decode
    import cmp_ccr_pkg::*;
#(
    parameter int SHORT_CYC = 4,
    parameter int LONG_CYC  = 6
) (
    input  logic [15:0] op,
    output cmp_dec_t    dec
);

    logic       group_ok;
    logic       size_ok;
    logic       mode_ok;
    logic       src_addr;
    logic [1:0] sz_bits;

    // Field extraction and legality of the word
    always_comb begin
        group_ok = (op[15:12] == 4'b1011);
        sz_bits  = op[7:6];
        size_ok  = !op[8] && (sz_bits != 2'b11);
        src_addr = op[3];
        // source mode must be 000 or 001; address source not allowed for byte
        mode_ok  = (op[5:4] == 2'b00) && !(src_addr && sz_bits == 2'b00);
    end

    // Assemble the decoded record
    always_comb begin
        dec.legal    = group_ok && size_ok && mode_ok;
        dec.size     = opsize_e'(sz_bits);
        dec.dst_idx  = op[11:9];
        dec.src_addr = src_addr;
        dec.src_idx  = op[2:0];
        dec.cyc      = (sz_bits == 2'b10) ? CYC_W'(LONG_CYC) : CYC_W'(SHORT_CYC);
    end

endmodule

// File: rtl/cmp_flag_alu.sv
// Module: cmp_flag_alu
// Combinational subtract-and-flag logic. One lane per operand width is built
// by a generate loop; the operand size picks the lane. Returns {N,Z,V,C}.
// Assumes the operands are held stable by the caller while the result is used.
module cmp_flag_alu
    import cmp_ccr_pkg::*;
(
    input  opsize_e          size,
    input  logic [REG_W-1:0] dst,
    input  logic [REG_W-1:0] src,
    output logic [3:0]       nzvc
);

    localparam int N_LANES = 3;

    logic [3:0] lane_flags [N_LANES];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int W = 8 << g;
        logic [W:0]   diff;
        logic         sd;
        logic         ss;
        logic         sr;

        // Width-W subtraction with a borrow bit on top
        always_comb begin
            diff = {1'b0, dst[W-1:0]} - {1'b0, src[W-1:0]};
            sd   = dst[W-1];
            ss   = src[W-1];
            sr   = diff[W-1];
            lane_flags[g] = {sr, (diff[W-1:0] == '0), (sd ^ ss) & (sr ^ sd), diff[W]};
        end
    end

    // Choose the lane for the current size
    always_comb begin
        case (size)
            SZ_BYTE: nzvc = lane_flags[0];
            SZ_WORD: nzvc = lane_flags[1];
            SZ_LONG: nzvc = lane_flags[2];
            default: nzvc = 4'b0000;
        endcase
    end

endmodule

// File: rtl/cmp_timer.sv
// Module: cmp_timer
// Execution-time counter. Loading a length N raises busy; the finishing edge
// comes N edges after the load edge and produces a one-cycle done.
// Assumes N >= 2 and that load is asserted only while busy is low.
module cmp_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          busy,
    output logic          finish,
    output logic          done
);

    logic [CW-1:0] remain;

    // Combinational marker of the edge at which the instruction ends
    always_comb finish = busy && (remain == CW'(1));

    // Countdown, busy and the completion strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                remain <= len;
                busy   <= 1'b1;
            end else if (finish) begin
                remain <= '0;
                busy   <= 1'b0;
                done   <= 1'b1;
            end else if (busy) begin
                remain <= remain - CW'(1);
            end
        end
    end

endmodule

// File: rtl/cmp_ccr_unit.sv
// Module: cmp_ccr_unit (top)
// Register-direct compare: decodes the word, reads both operands through the
// combinational register read port, captures them on acceptance, times the
// instruction and writes {X,N,Z,V,C} at completion. Never writes registers.
// Assumes dst_data and src_data follow dst_sel and src_sel in the same cycle.
module cmp_ccr_unit
    import cmp_ccr_pkg::*;
#(
    parameter int SHORT_CYC = 4,
    parameter int LONG_CYC  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [15:0]      opcode,
    input  logic             cc_x_in,
    output logic [2:0]       dst_sel,
    input  logic [REG_W-1:0] dst_data,
    output logic [3:0]       src_sel,
    input  logic [REG_W-1:0] src_data,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic [CYC_W-1:0] cycles,
    output logic [4:0]       cc_out
);

    cmp_dec_t         dec;
    logic             accept;
    logic             go;
    logic             finish;
    logic [REG_W-1:0] dst_q;
    logic [REG_W-1:0] src_q;
    opsize_e          size_q;
    logic             x_q;
    logic [CYC_W-1:0] cyc_q;
    logic             ill_q;
    logic [4:0]       cc_q;
    logic [3:0]       nzvc;

    cmp_decode #(
        .SHORT_CYC(SHORT_CYC),
        .LONG_CYC (LONG_CYC)
    ) u_dec (
        .op (opcode),
        .dec(dec)
    );

    // Register-file read selects come straight from the word
    always_comb begin
        dst_sel = dec.dst_idx;
        src_sel = {dec.src_addr, dec.src_idx};
    end

    // Acceptance only while idle; legal words start the timer
    always_comb begin
        accept = start && !busy;
        go     = accept && dec.legal;
    end

    cmp_timer #(
        .CW(CYC_W)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (go),
        .len   (dec.cyc),
        .busy  (busy),
        .finish(finish),
        .done  (done)
    );

    // Operand and context capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q  <= '0;
            src_q  <= '0;
            size_q <= SZ_BYTE;
            x_q    <= 1'b0;
            cyc_q  <= '0;
        end else if (go) begin
            dst_q  <= dst_data;
            src_q  <= src_data;
            size_q <= dec.size;
            x_q    <= cc_x_in;
            cyc_q  <= dec.cyc;
        end
    end

    // Illegal-instruction strobe, one cycle per refused word
    always_ff @(posedge clk) begin
        if (!rst_n) ill_q <= 1'b0;
        else        ill_q <= accept && !dec.legal;
    end

    cmp_flag_alu u_alu (
        .size(size_q),
        .dst (dst_q),
        .src (src_q),
        .nzvc(nzvc)
    );

    // Condition bits are written only at the finishing edge
    always_ff @(posedge clk) begin
        if (!rst_n)      cc_q <= '0;
        else if (finish) cc_q <= {x_q, nzvc};
    end

    // Output drive
    always_comb begin
        illegal = ill_q;
        cycles  = cyc_q;
        cc_out  = cc_q;
    end

endmodule

// File: rtl/cmp_ccr_chk.sv
// Module: cmp_ccr_chk
// Temporal checks on the compare unit's ports, bound into every instance.
// Assumes the default cycle counts unless overridden through parameters.
module cmp_ccr_chk #(
    parameter int SHORT_CYC = 4,
    parameter int LONG_CYC  = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       illegal,
    input logic [3:0] cycles,
    input logic [4:0] cc_out
);

    logic [3:0] run_len;

    // Cycles spent busy since the instruction was accepted
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) run_len <= '0;
        else                 run_len <= run_len + 4'd1;
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(cc_out));

    // R7
    ill_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!done && !busy));

    // R5
    len_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_len == cycles - 4'd1) |=> done);

    // R5
    cyc_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cycles == 4'(SHORT_CYC) || cycles == 4'(LONG_CYC)));

    // R9
    busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_len < cycles - 4'd1) |=> (busy && !done));

endmodule

bind cmp_ccr_unit cmp_ccr_chk #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .illegal(illegal), .cycles(cycles), .cc_out(cc_out)
);

// File: tb/tb_cmp_ccr_unit.sv
// Scoreboard bench: the driver predicts each instruction's outcome and queues
// it; the monitor pops and compares whenever done or illegal appears.
module tb_cmp_ccr_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic       ill;
        logic [4:0] cc;
        logic [3:0] cyc;
        string      req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] opcode = 16'h0000;
    logic        cc_x_in = 1'b0;
    logic [2:0]  dst_sel;
    logic [31:0] dst_data;
    logic [3:0]  src_sel;
    logic [31:0] src_data;
    logic        busy, done, illegal;
    logic [3:0]  cycles;
    logic [4:0]  cc_out;

    logic [31:0] dregs [8];
    logic [31:0] aregs [8];
    exp_t        sbq [$];
    logic [4:0]  model_cc = 5'd0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign dst_data = dregs[dst_sel];
    assign src_data = src_sel[3] ? aregs[src_sel[2:0]] : dregs[src_sel[2:0]];

    cmp_ccr_unit dut (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .cc_x_in(cc_x_in), .dst_sel(dst_sel), .dst_data(dst_data),
        .src_sel(src_sel), .src_data(src_data), .busy(busy), .done(done),
        .illegal(illegal), .cycles(cycles), .cc_out(cc_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Reference flags from the R2 definition
    function automatic logic [3:0] ref_nzvc(input logic [1:0] sz,
                                            input logic [31:0] d, input logic [31:0] s);
        int w;
        logic [31:0] m, dm, sm, r;
        w  = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        m  = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        dm = d & m;
        sm = s & m;
        r  = (dm - sm) & m;
        return {r[w-1], r == 32'h0, (dm[w-1] != sm[w-1]) && (r[w-1] != dm[w-1]), sm > dm};
    endfunction

    // Driver: predict, queue, issue, and time the instruction
    task automatic issue(input logic [15:0] op, input logic x, input bit poke, input string req);
        exp_t e;
        bit legal;
        logic [31:0] sv;
        int n;
        legal = (op[15:12] == 4'b1011) && !op[8] && (op[7:6] != 2'b11)
                && (op[5:4] == 2'b00) && !(op[3] && op[7:6] == 2'b00);
        sv = op[3] ? aregs[op[2:0]] : dregs[op[2:0]];
        e.ill = !legal;
        e.cyc = (op[7:6] == 2'b10) ? 4'd6 : 4'd4;
        e.req = req;
        if (legal) model_cc = {x, ref_nzvc(op[7:6], dregs[op[11:9]], sv)};
        e.cc = model_cc;
        sbq.push_back(e);
        @(negedge clk);
        opcode = op; cc_x_in = x; start = 1'b1;
        #1;
        // R1: selects follow the word fields
        chk(dst_sel == op[11:9], "R1", "dst_sel", 32'(dst_sel), 32'(op[11:9]));
        chk(src_sel == {op[3], op[2:0]}, "R1", "src_sel", 32'(src_sel), 32'({op[3], op[2:0]}));
        @(negedge clk);
        start = 1'b0;
        if (!legal) begin
            // R7: pulse visible right after the accepting edge
            chk(illegal === 1'b1, "R7", "illegal pulse", 32'(illegal), 1);
            @(negedge clk);
            chk(illegal === 1'b0 && busy === 1'b0, "R7", "illegal one cycle", 32'({illegal, busy}), 0);
        end else begin
            n = 0;
            do begin
                @(negedge clk);
                n++;
                if (poke && n == 2) begin
                    opcode = 16'hB401; cc_x_in = ~x; start = 1'b1;
                end else begin
                    start = 1'b0;
                end
            end while (!done && n < 20);
            chk(n == int'(e.cyc), req, "latency", 32'(n), 32'(e.cyc));
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare each completion or refusal with the queue head
    always @(negedge clk) begin
        if (rst_n && (done || illegal)) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R9", "unexpected completion", 32'({done, illegal}), 0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(illegal == e.ill, e.req, "kind", 32'(illegal), 32'(e.ill));
                chk(cc_out == e.cc, e.req, "cc_out", 32'(cc_out), 32'(e.cc));
                if (!e.ill) chk(cycles == e.cyc, e.req, "cycles", 32'(cycles), 32'(e.cyc));
            end
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) begin dregs[i] = 32'h0; aregs[i] = 32'h0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cc_out == 5'd0 && !busy && !done && !illegal, "R8", "reset state",
            32'({cc_out, busy, done, illegal}), 0);

        dregs[1] = 32'h1234567F; dregs[2] = 32'h12345680;
        issue(16'hB401, 1'b0, 1'b0, "R2");        // byte: 0x80 - 0x7F
        chk(cc_out == 5'h02, "R2", "byte V only", 32'(cc_out), 32'h02);
        issue(16'hB202, 1'b0, 1'b0, "R2");        // byte: 0x7F - 0x80
        chk(cc_out == 5'h0B, "R2", "byte NVC", 32'(cc_out), 32'h0B);

        dregs[1] = 32'h12347002; dregs[2] = 32'h12348004;
        issue(16'hB242, 1'b0, 1'b0, "R3");        // word
        chk(cc_out == 5'h0B, "R3", "word NVC", 32'(cc_out), 32'h0B);
        issue(16'hB282, 1'b0, 1'b0, "R5");        // long, six cycles
        chk(cc_out == 5'h09, "R5", "long NC", 32'(cc_out), 32'h09);

        dregs[1] = 32'h55555555; dregs[2] = 32'h66666666;
        issue(16'hB242, 1'b1, 1'b0, "R4");        // word, X carried
        chk(cc_out == 5'h19, "R4", "X kept with NC", 32'(cc_out), 32'h19);

        dregs[1] = 32'hFFFFFF05; dregs[2] = 32'h00000005;
        issue(16'hB202, 1'b0, 1'b0, "R3");        // byte, upper junk
        chk(cc_out == 5'h04, "R3", "byte Z from low lane", 32'(cc_out), 32'h04);

        dregs[1] = 32'h00007002; aregs[2] = 32'h77778004;
        issue(16'hB24A, 1'b0, 1'b0, "R6");        // word, address source
        chk(cc_out == 5'h0B, "R6", "word addr NVC", 32'(cc_out), 32'h0B);
        dregs[1] = 32'h80000000; aregs[2] = 32'h00000001;
        issue(16'hB28A, 1'b1, 1'b0, "R6");        // long, address source

        issue(16'h9401, 1'b0, 1'b0, "R7");        // wrong group
        issue(16'hB409, 1'b0, 1'b0, "R7");        // byte with address source
        issue(16'hB4C1, 1'b0, 1'b0, "R7");        // size 011
        issue(16'hB411, 1'b0, 1'b0, "R7");        // memory source mode
        chk(cc_out == model_cc, "R7", "flags untouched", 32'(cc_out), 32'(model_cc));

        dregs[1] = 32'h00000001; dregs[2] = 32'h00000001;
        issue(16'hB282, 1'b0, 1'b1, "R9");        // long equal, start poked mid-run
        chk(cc_out == 5'h04, "R9", "first instruction wins", 32'(cc_out), 32'h04);
        repeat (10) @(negedge clk);
        chk(sbq.size() == 0 && !busy, "R9", "no stray work", 32'(sbq.size()), 0);

        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule